// File: doc/BRIEF.md
# Half-Duplex MAC Transmit Scheduler

This block decides the clock cycle in which an Ethernet MAC may begin sending a frame. All of its timing is measured in nibble times, supplied as a one-cycle strobe on `tick_i`. After every transmission attempt it holds off the next start by a programmable inter-frame gap. The gap is the 7-bit `gap_i` value plus a fixed offset: 3 nibble times in full duplex and 6 in half duplex. With the nominal settings of 0x15 and 0x12, both modes give 24 nibble times, which is 9.6 µs at 10 Mb/s.

In half duplex the block also handles shared-medium access. It waits while carrier is sensed. It can either wait indefinitely or drop the frame after a limit of continuous busy medium. After a collision it retries at once or waits a binary exponential backoff drawn from a free-running 16-bit LFSR. Collisions that occur while backpressure is applied have their own bypass bit. A frame that collides `MAX_ATTEMPTS` times is dropped. In full duplex, carrier and collision inputs have no effect.

The MAC holds `req_i` high while it has a frame to send. It starts sending on `grant_o`, then reports the end of transmission on `tx_end_i` or a collision on `collision_i`. Data path, CRC, preamble and jam generation live elsewhere.

Top module: `mts_sched`

## Requirements
- R1: After reset, `grant_o`, `done_o` and `abort_o` are low, and the gap and backoff timers are clear. A request against an idle medium is granted at the first clock edge that samples `req_i` high.
- R2: An attempt ends at the edge that samples `tx_end_i` or a half-duplex `collision_i` while transmitting. From that edge, no grant is given until N ticks have passed, where N = `gap_i` + 3 in full duplex and `gap_i` + 6 in half duplex. The grant appears at the edge after the N-th tick. With `tick_i` held high, this is the (N+1)-th edge after the end. Cycles without a tick do not count.
- R3: `grant_o` is a one-cycle pulse. `done_o` pulses for one cycle, registered from the edge that samples `tx_end_i` with no half-duplex collision. At most one of `grant_o`, `done_o` and `abort_o` is high in any cycle.
- R4: In half duplex, no grant is given while `carrier_i` is high. Once the gap has expired, the grant comes at the first edge that samples `carrier_i` low.
- R5: In half duplex with `defer_forever_i` low, a pending request that sees `carrier_i` high for `DEFER_LIMIT` consecutive ticks is dropped. `abort_o` is raised at the next edge with `abort_cause_o` = 0. One cycle of idle medium restarts the count.
- R6: In half duplex with `defer_forever_i` high, a busy medium never causes an abort, however long it lasts.
- R7: With `no_backoff_i` high, the delay after a collision is the gap alone: the grant comes at the (N+1)-th edge with `tick_i` high.
- R8: With both bypass bits inactive, the n-th collision of a frame is followed by a wait of max(N, r·`SLOT_NIB`) ticks before the grant. Here r is an integer from 0 to 2^min(n,`BACKOFF_CAP`)−1.
- R9: A collision sampled while `backpressure_i` is high is followed by the gap alone when `bp_no_backoff_i` is high. When `bp_no_backoff_i` is low, it is followed by the R8 backoff.
- R10: The `MAX_ATTEMPTS`-th collision of one frame drops it. `abort_o` pulses at that edge with `abort_cause_o` = 1. The attempt count restarts with every new frame.
- R11: In full duplex, `carrier_i` never withholds a grant, and `collision_i` neither ends a transmission nor aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per nibble time |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| gap_i | input | 7 | Programmed back-to-back gap, nibble times less the duplex offset |
| defer_forever_i | input | 1 | 1 = wait on busy medium without limit |
| no_backoff_i | input | 1 | 1 = no backoff after any collision |
| bp_no_backoff_i | input | 1 | 1 = no backoff after a collision during backpressure |
| req_i | input | 1 | Frame pending, held until done or abort |
| carrier_i | input | 1 | Carrier sense |
| collision_i | input | 1 | Collision strobe during transmission |
| backpressure_i | input | 1 | Backpressure being applied |
| tx_end_i | input | 1 | Transmission finished strobe |
| grant_o | output | 1 | Start-of-transmission pulse |
| done_o | output | 1 | Frame sent pulse |
| abort_o | output | 1 | Frame dropped pulse |
| abort_cause_o | output | 1 | 0 = excessive deferral, 1 = excessive collisions |

## Verification
Every result is registered once. `done_o` and a collision abort appear in the cycle right after the edge that sampled the end or collision. With ticks every cycle, the grant after an end lands on exactly the (N+1)-th edge, or on the (N+1+wait)-th edge after a backoff. A deferral abort lands on edge `DEFER_LIMIT`+1 after the end. The bench drives inputs on the falling edge and counts rising edges from the end event, then samples on the following falling edge. Exact edge counts are compared where the result is deterministic. For a random backoff, each delay is checked against the set of legal values, and at least one nonzero wait must be seen.

// File: rtl/mts_pkg.sv
package mts_pkg;
  typedef enum logic {ST_WAIT = 1'b0, ST_TX = 1'b1} mts_state_e;
  typedef enum logic {CAUSE_DEFER = 1'b0, CAUSE_COLL = 1'b1} mts_cause_e;
  localparam int unsigned FD_GAP_OFF = 3;
  localparam int unsigned HD_GAP_OFF = 6;
endpackage

// File: rtl/mts_gap_timer.sv
module mts_gap_timer #(
  parameter int unsigned GAP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             fd_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             zero_o
);
  localparam int unsigned CNT_W = GAP_W + 1;
  logic [CNT_W-1:0] cnt_q, load_val;

  assign load_val = CNT_W'(gap_i) +
                    (fd_i ? CNT_W'(mts_pkg::FD_GAP_OFF) : CNT_W'(mts_pkg::HD_GAP_OFF));
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val;
    else if (tick_i && !zero_o)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_gap_loaded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !zero_o);
  assert_gap_tick_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mts_defer_timer.sv
module mts_defer_timer #(
  parameter int unsigned LIMIT = 6072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic busy_i,
  input  logic clear_i,
  output logic hit_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = (cnt_q >= CNT_W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i || !busy_i)  cnt_q <= '0;   // continuous busy only
    else if (tick_i && !hit_o)    cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_defer_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !hit_o);
endmodule

// File: rtl/mts_backoff.sv
module mts_backoff #(
  parameter int unsigned SLOT_NIB = 128,
  parameter int unsigned CAP      = 10,
  parameter int unsigned ATT_W    = 5,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             skip_i,
  input  logic [ATT_W-1:0] attempt_i,
  output logic             zero_o
);
  localparam int unsigned CNT_W = CAP + $clog2(SLOT_NIB) + 1;
  logic [15:0]      lfsr_q;
  logic [CAP-1:0]   mask, pick;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  // window 2^min(n,CAP)-1
  always_comb begin
    for (int i = 0; i < int'(CAP); i++) mask[i] = (i < int'(attempt_i));
  end
  assign pick   = lfsr_q[CAP-1:0] & mask;
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= skip_i ? '0 : CNT_W'(pick) * CNT_W'(SLOT_NIB);
    else if (tick_i && !zero_o) cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_skip_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && skip_i) |=> zero_o);
  assert_slot_multiple_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !skip_i) |=> ((cnt_q % CNT_W'(SLOT_NIB)) == '0));
endmodule

// File: rtl/mts_sched.sv
module mts_sched #(
  parameter int unsigned GAP_W        = 7,
  parameter int unsigned SLOT_NIB     = 128,
  parameter int unsigned BACKOFF_CAP  = 10,
  parameter int unsigned MAX_ATTEMPTS = 16,
  parameter int unsigned DEFER_LIMIT  = 6072
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             full_duplex_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             defer_forever_i,
  input  logic             no_backoff_i,
  input  logic             bp_no_backoff_i,
  input  logic             req_i,
  input  logic             carrier_i,
  input  logic             collision_i,
  input  logic             backpressure_i,
  input  logic             tx_end_i,
  output logic             grant_o,
  output logic             done_o,
  output logic             abort_o,
  output logic             abort_cause_o
);
  import mts_pkg::*;
  localparam int unsigned ATT_W = $clog2(MAX_ATTEMPTS + 1);

  mts_state_e       st_q;
  logic [ATT_W-1:0] att_q, att_next;
  logic gap_zero, bo_zero, defer_hit;
  logic in_tx, in_wait, coll, tx_stop, ready, grant_set;
  logic abort_def, abort_col, end_ok, bo_skip, busy_wait;

  assign in_tx     = (st_q == ST_TX);
  assign in_wait   = (st_q == ST_WAIT);
  assign coll      = in_tx && !full_duplex_i && collision_i;
  assign tx_stop   = in_tx && (coll || tx_end_i);
  assign end_ok    = in_tx && tx_end_i && !coll;
  assign att_next  = att_q + ATT_W'(1);
  assign abort_col = coll && (att_next >= ATT_W'(MAX_ATTEMPTS));
  assign bo_skip   = no_backoff_i || (backpressure_i && bp_no_backoff_i);
  assign busy_wait = in_wait && req_i && !full_duplex_i && carrier_i;
  assign abort_def = busy_wait && !defer_forever_i && defer_hit;
  assign ready     = req_i && gap_zero && bo_zero && (full_duplex_i || !carrier_i);
  assign grant_set = in_wait && ready;

  mts_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i, .rst_ni, .tick_i,
    .load_i (tx_stop),
    .fd_i   (full_duplex_i),
    .gap_i,
    .zero_o (gap_zero)
  );

  mts_defer_timer #(.LIMIT(DEFER_LIMIT)) u_defer (
    .clk_i, .rst_ni, .tick_i,
    .busy_i  (busy_wait),
    .clear_i (abort_def),
    .hit_o   (defer_hit)
  );

  mts_backoff #(.SLOT_NIB(SLOT_NIB), .CAP(BACKOFF_CAP), .ATT_W(ATT_W)) u_bo (
    .clk_i, .rst_ni, .tick_i,
    .load_i    (coll && !abort_col),
    .skip_i    (bo_skip),
    .attempt_i (att_next),
    .zero_o    (bo_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_WAIT;
      att_q         <= '0;
      grant_o       <= 1'b0;
      done_o        <= 1'b0;
      abort_o       <= 1'b0;
      abort_cause_o <= CAUSE_DEFER;
    end else begin
      grant_o <= grant_set;
      done_o  <= end_ok;
      abort_o <= abort_def || abort_col;
      if (abort_col)      abort_cause_o <= CAUSE_COLL;
      else if (abort_def) abort_cause_o <= CAUSE_DEFER;

      if (grant_set)    st_q <= ST_TX;
      else if (tx_stop) st_q <= ST_WAIT;

      if (end_ok || abort_col || abort_def) att_q <= '0;
      else if (coll)                        att_q <= att_next;
    end
  end

  assert_one_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, done_o, abort_o}));
  assert_grant_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
  assert_grant_after_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(gap_zero && bo_zero));
  assert_no_grant_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(full_duplex_i || !carrier_i));
  assert_defer_abort_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && abort_cause_o == CAUSE_DEFER) |-> $past(!defer_forever_i && carrier_i));
  assert_attempt_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q < ATT_W'(MAX_ATTEMPTS));
  assert_fd_no_coll_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && abort_cause_o == CAUSE_COLL) |-> $past(!full_duplex_i));
endmodule

// File: tb/sim_mts_sched.sv
module sim_mts_sched;
  localparam int SLOT = 16;
  localparam int LIM  = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, fd = 1'b0, dfor = 1'b0, nobo = 1'b0, bpnb = 1'b0;
  logic req = 1'b0, carrier = 1'b0, coll = 1'b0, bp = 1'b0, tend = 1'b0;
  logic [6:0] gap = '0;
  logic grant, done, abrt, cause;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  mts_sched #(.SLOT_NIB(SLOT), .DEFER_LIMIT(LIM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .full_duplex_i(fd), .gap_i(gap),
    .defer_forever_i(dfor), .no_backoff_i(nobo), .bp_no_backoff_i(bpnb),
    .req_i(req), .carrier_i(carrier), .collision_i(coll), .backpressure_i(bp),
    .tx_end_i(tend), .grant_o(grant), .done_o(done), .abort_o(abrt),
    .abort_cause_o(cause)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int gap_n(input int g, input bit f);
    return g + (f ? 3 : 6);
  endfunction

  function automatic bit beb_ok(input int d, input int n, input int nn);
    int top;
    top = (1 << ((n < 10) ? n : 10)) - 1;
    if (d == nn) return 1'b1;
    return (d > nn) && (d % SLOT == 0) && (d / SLOT >= 1) && (d / SLOT <= top);
  endfunction

  // ev: 1 grant, 2 abort; k = rising edges counted from the call
  task automatic meas(output int k, output int ev);
    k = 0; ev = 0;
    while (ev == 0 && k < 20000) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (grant) ev = 1;
      else if (abrt) ev = 2;
    end
  endtask

  task automatic end_tx(input bit by_coll);
    if (by_coll) coll = 1'b1; else tend = 1'b1;
    @(posedge clk);
    @(negedge clk);
    coll = 1'b0; tend = 1'b0;
  endtask

  task automatic quiet(input int n, output int evs);
    evs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (grant || abrt) evs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k, ev, evs, nlong, exp;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!grant && !done && !abrt, "R1", {grant, done, abrt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    req = 1'b1;
    meas(k, ev);
    chk(ev == 1 && k == 1, "R1", k, 1);

    // R2 random gaps and duplex
    for (int i = 0; i < 20; i++) begin
      gap = 7'($urandom_range(0, 127));
      fd  = 1'($urandom_range(0, 1));
      end_tx(1'b0);
      chk(done == 1'b1, "R3", done, 1);
      meas(k, ev);
      exp = gap_n(gap, fd) + 1;
      chk(ev == 1 && k == exp, "R2", k, exp);
      @(posedge clk); @(negedge clk);
      chk(grant == 1'b0, "R3", grant, 0);
    end

    // R2 only ticks count
    begin
      int c, tks, last;
      gap = 7'd2; fd = 1'b0;
      end_tx(1'b0);
      c = 0; tks = 0; last = 0;
      while (!grant && c < 1000) begin
        tick = (c % 3 == 2);
        @(posedge clk); last = tick; tks += last; c++;
        @(negedge clk);
      end
      tick = 1'b1;
      chk(grant && (tks - last) == 8, "R2", tks - last, 8);
    end

    // R4 carrier holds off grant
    gap = 7'd0; fd = 1'b0; carrier = 1'b1;
    end_tx(1'b0);
    quiet(30, evs);
    chk(evs == 0, "R4", evs, 0);
    carrier = 1'b0;
    meas(k, ev);
    chk(ev == 1 && k == 1, "R4", k, 1);

    // R6 endless deferral
    dfor = 1'b1; carrier = 1'b1;
    end_tx(1'b0);
    quiet(LIM + 50, evs);
    chk(evs == 0, "R6", evs, 0);
    carrier = 1'b0;
    meas(k, ev);
    chk(ev == 1 && k == 1, "R6", k, 1);
    dfor = 1'b0;

    // R5 idle cycle restarts busy count
    gap = 7'd127; carrier = 1'b1;
    end_tx(1'b0);
    quiet(100, evs);
    carrier = 1'b0;
    quiet(1, k); evs += k;
    carrier = 1'b1;
    quiet(150, k); evs += k;
    chk(evs == 0, "R5", evs, 0);
    carrier = 1'b0;
    meas(k, ev);
    chk(ev == 1 && k == 1, "R5", k, 1);

    // R5 excessive deferral abort
    gap = 7'd0; carrier = 1'b1;
    end_tx(1'b0);
    meas(k, ev);
    chk(ev == 2 && k == LIM + 1, "R5", k, LIM + 1);
    chk(cause == 1'b0, "R5", cause, 0);
    req = 1'b0; carrier = 1'b0;
    quiet(5, evs);
    chk(evs == 0, "R5", evs, 0);
    req = 1'b1;
    meas(k, ev);
    chk(ev == 1 && k == 1, "R5", k, 1);

    // R7 no backoff
    nobo = 1'b1;
    for (int i = 0; i < 5; i++) begin
      end_tx(1'b1);
      meas(k, ev);
      chk(ev == 1 && k == 7, "R7", k, 7);
    end
    end_tx(1'b0);
    meas(k, ev);
    nobo = 1'b0;

    // R8 exponential backoff
    nlong = 0;
    for (int n = 1; n <= 8; n++) begin
      end_tx(1'b1);
      meas(k, ev);
      chk(ev == 1 && beb_ok(k - 1, n, 6), "R8", k - 1, 6);
      if (k - 1 > 6) nlong++;
    end
    chk(nlong > 0, "R8", nlong, 1);
    end_tx(1'b0);
    meas(k, ev);

    // R9 backpressure bypass on / off
    bp = 1'b1; bpnb = 1'b1;
    for (int i = 0; i < 8; i++) begin
      end_tx(1'b1);
      meas(k, ev);
      chk(ev == 1 && k == 7, "R9", k, 7);
    end
    end_tx(1'b0);
    meas(k, ev);
    bpnb = 1'b0; nlong = 0;
    for (int n = 1; n <= 8; n++) begin
      end_tx(1'b1);
      meas(k, ev);
      chk(ev == 1 && beb_ok(k - 1, n, 6), "R9", k - 1, 6);
      if (k - 1 > 6) nlong++;
    end
    chk(nlong > 0, "R9", nlong, 1);
    end_tx(1'b0);
    meas(k, ev);
    bp = 1'b0;

    // R10 attempt limit
    nobo = 1'b1; evs = 0;
    for (int i = 0; i < 15; i++) begin
      end_tx(1'b1);
      if (abrt) evs++;
      meas(k, ev);
      if (ev != 1 || k != 7) evs++;
    end
    chk(evs == 0, "R10", evs, 0);
    end_tx(1'b1);
    chk(abrt == 1'b1, "R10", abrt, 1);
    chk(cause == 1'b1, "R10", cause, 1);
    req = 1'b0;
    quiet(10, evs);
    chk(evs == 0, "R10", evs, 0);
    req = 1'b1;
    meas(k, ev);
    chk(ev == 1 && k == 1, "R10", k, 1);
    nobo = 1'b0;

    // R11 full duplex ignores carrier and collision
    fd = 1'b1; carrier = 1'b1; evs = 0;
    for (int i = 0; i < 20; i++) begin
      end_tx(1'b1);
      if (grant || abrt || done) evs++;
      quiet(1, k); evs += k;
    end
    chk(evs == 0, "R11", evs, 0);
    end_tx(1'b0);
    chk(done == 1'b1, "R11", done, 1);
    meas(k, ev);
    chk(ev == 1 && k == 4, "R11", k, 4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule